// File: doc/BRIEF.md
# Conditional Floating-Point Compare Flag Unit

This block evaluates one conditional floating-point compare per valid strobe and keeps the four condition flags (N, Z, C, V) that result. The instruction word carries an operand format, a 4-bit condition code, a NaN-signalling control bit and a 4-bit fallback flag value. The unit first tests the condition code against the flags it currently holds. If the condition holds, it compares the two operands under IEEE 754 ordering rules and turns the outcome into a flag pattern. If the condition fails, the fallback value from the instruction is loaded into the flags.

Operands come in on 64-bit inputs. Half and single formats use only the low bits of each input. An invalid-operation pulse reports a NaN that the compare is required to signal. An undefined pulse reports an encoding the unit does not accept, and in that case the flags are left as they were. All outputs are registered and update on the clock edge that samples `valid_i`.

Top module: `fcc_flag_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `flags_o` is 0000 and both `invalid_o` and `undef_o` are 0.
- R2: An accepted word has bits 31..29 = 000, bits 28..24 = 11110, bit 21 = 1 and bits 11..10 = 01. Any other value gives an `undef_o` pulse, and `flags_o` keeps its previous value.
- R3: The format field is bits 23..22. The value 00 selects single precision, 01 selects double and 11 selects half. The value 11 is accepted only when `half_en_i` = 1. The value 10 is always undefined, and so is 11 when `half_en_i` = 0.
- R4: The condition code is bits 15..12 and the fallback value is bits 3..0. When the condition fails, the fallback value is written to `flags_o` unchanged.
- R5: `flags_o` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Codes 0/1 test Z set/clear, 2/3 test C set/clear, 4/5 test N set/clear and 6/7 test V set/clear. Code 8 is C and not Z, and 9 is its inverse. Code 10 is N equal to V, and 11 is its inverse. Code 12 is Z clear and N equal to V, and 13 is its inverse. Codes 14 and 15 always hold.
- R6: With the condition holding and both operands ordered, equal operands give 0110, first operand less gives 1000 and first operand greater gives 0010.
- R7: +0 and -0 compare equal. Infinities order by sign: -inf is less than +inf, and equal infinities compare equal.
- R8: If either operand is a NaN, the flags become 0011.
- R9: With bit 4 = 0, `invalid_o` pulses only when an operand is a signalling NaN (all-ones exponent, non-zero fraction, fraction MSB 0). Quiet NaNs do not raise it.
- R10: With bit 4 = 1, `invalid_o` pulses for any NaN operand.
- R11: When the condition fails, `invalid_o` stays 0 even for signalling NaN operands.
- R12: Without `valid_i`, `flags_o` holds its value, and `invalid_o` and `undef_o` are single-cycle pulses that return to 0.
- R13: For half and single formats, operand bits above the format width have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: evaluate the presented instruction this cycle |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 64 | First operand, low-aligned |
| opb_i | input | 64 | Second operand, low-aligned |
| half_en_i | input | 1 | Half precision format permitted |
| flags_o | output | 4 | Current N, Z, C, V flags |
| invalid_o | output | 1 | Invalid-operation pulse |
| undef_o | output | 1 | Undefined-encoding pulse |

## Verification
The assertions assume that `valid_i` and `instr_i` hold defined values at every clock edge after reset. They also assume that `valid_i` is low during reset, so the first history sample is clean. The bench drives every input only on falling edges and holds `valid_i` for exactly one rising edge per operation. It samples outputs on the next falling edge, while the pulses are still visible. Operand values are fixed encodings chosen to hit each class: zeros, infinities, quiet and signalling NaNs, and normal numbers.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        FT_SINGLE = 2'b00,
        FT_DOUBLE = 2'b01,
        FT_BAD    = 2'b10,
        FT_HALF   = 2'b11
    } ftype_e;

    localparam int NUM_FMT = 3;  // slot 0 half, 1 single, 2 double

    localparam logic [3:0] FLG_EQ = 4'b0110;
    localparam logic [3:0] FLG_LT = 4'b1000;
    localparam logic [3:0] FLG_GT = 4'b0010;
    localparam logic [3:0] FLG_UN = 4'b0011;

    typedef struct packed {
        ftype_e     ftype;
        logic [3:0] cond;
        logic       sig_all;
        logic [3:0] imm;
    } dec_t;

    typedef struct packed {
        logic any_nan;
        logic any_snan;
        logic eq;
        logic lt;
    } cmp_t;

    function automatic int fmt_exp_w(input int slot);
        case (slot)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_man_w(input int slot);
        case (slot)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    // flag order: [3]=N [2]=Z [1]=C [0]=V
    function automatic logic cond_holds(input logic [3:0] code, input logic [3:0] f);
        logic base;
        case (code[3:1])
            3'd0: base = f[2];
            3'd1: base = f[1];
            3'd2: base = f[3];
            3'd3: base = f[0];
            3'd4: base = f[1] & ~f[2];
            3'd5: base = (f[3] == f[0]);
            3'd6: base = ~f[2] & (f[3] == f[0]);
            default: base = 1'b1;
        endcase
        if (code[3:1] != 3'd7 && code[0]) base = ~base;
        return base;
    endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        half_en_i,
    output dec_t        dec_o,
    output logic [1:0]  slot_o,
    output logic        undef_o
);
    logic shape_ok;
    logic type_ok;

    always_comb begin
        shape_ok = (instr_i[31:29] == 3'b000) && (instr_i[28:24] == 5'b11110) &&
                   instr_i[21] && (instr_i[11:10] == 2'b01);
        dec_o.ftype   = ftype_e'(instr_i[23:22]);
        dec_o.cond    = instr_i[15:12];
        dec_o.sig_all = instr_i[4];
        dec_o.imm     = instr_i[3:0];
        case (dec_o.ftype)
            FT_HALF:   begin type_ok = half_en_i; slot_o = 2'd0; end
            FT_SINGLE: begin type_ok = 1'b1;      slot_o = 2'd1; end
            FT_DOUBLE: begin type_ok = 1'b1;      slot_o = 2'd2; end
            default:   begin type_ok = 1'b0;      slot_o = 2'd1; end
        endcase
        undef_o = ~(shape_ok & type_ok);
    end
endmodule

// File: rtl/fcc_fmt_cmp.sv
module fcc_fmt_cmp
    import fcc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    output cmp_t                 res_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic             sa, sb;
    logic [W-2:0]     ma, mb;
    logic             nan_a, nan_b, snan_a, snan_b, zeros;

    always_comb begin
        sa = a_i[W-1];
        sb = b_i[W-1];
        ma = a_i[W-2:0];
        mb = b_i[W-2:0];
        nan_a  = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
        nan_b  = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
        snan_a = nan_a && !a_i[MAN_W-1];
        snan_b = nan_b && !b_i[MAN_W-1];
        zeros  = (ma == '0) && (mb == '0);

        res_o.any_nan  = nan_a | nan_b;
        res_o.any_snan = snan_a | snan_b;
        res_o.eq       = zeros || (a_i == b_i);
        if (zeros)         res_o.lt = 1'b0;
        else if (sa != sb) res_o.lt = sa;
        else if (sa)       res_o.lt = (ma > mb);
        else               res_o.lt = (ma < mb);
    end
endmodule

// File: rtl/fcc_flag_unit.sv
module fcc_flag_unit
    import fcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [63:0] opa_i,
    input  logic [63:0] opb_i,
    input  logic        half_en_i,
    output logic [3:0]  flags_o,
    output logic        invalid_o,
    output logic        undef_o
);
    dec_t       dec;
    logic [1:0] slot;
    logic       undef_c;
    cmp_t       res [NUM_FMT];
    cmp_t       sel;
    logic [3:0] cmp_flags;
    logic       pass;
    logic       inv_c;

    fcc_decode dec_i (
        .instr_i   (instr_i),
        .half_en_i (half_en_i),
        .dec_o     (dec),
        .slot_o    (slot),
        .undef_o   (undef_c)
    );

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int MW = fmt_man_w(g);
        fcc_fmt_cmp #(.EXP_W(EW), .MAN_W(MW)) cmp_i (
            .a_i   (opa_i[EW+MW:0]),
            .b_i   (opb_i[EW+MW:0]),
            .res_o (res[g])
        );
    end

    always_comb begin
        sel  = res[slot];
        pass = cond_holds(dec.cond, flags_o);
        if (sel.any_nan)  cmp_flags = FLG_UN;
        else if (sel.eq)  cmp_flags = FLG_EQ;
        else if (sel.lt)  cmp_flags = FLG_LT;
        else              cmp_flags = FLG_GT;
        inv_c = sel.any_snan | (dec.sig_all & sel.any_nan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o   <= 4'b0000;
            invalid_o <= 1'b0;
            undef_o   <= 1'b0;
        end else begin
            invalid_o <= 1'b0;
            undef_o   <= 1'b0;
            if (valid_i) begin
                if (undef_c) begin
                    undef_o <= 1'b1;
                end else if (pass) begin
                    flags_o   <= cmp_flags;
                    invalid_o <= inv_c;
                end else begin
                    flags_o <= dec.imm;
                end
            end
        end
    end
endmodule

// File: rtl/fcc_flag_chk.sv
module fcc_flag_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [31:0] instr_i,
    input logic [3:0]  flags_o,
    input logic        invalid_o,
    input logic        undef_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(valid_i)) |-> (flags_o == $past(flags_o)));

    assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(valid_i)) |-> (!invalid_o && !undef_o));

    assert_undef_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && undef_o) |-> (flags_o == $past(flags_o)));

    assert_badtype_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && ($past(instr_i[23:22]) == 2'b10)) |-> undef_o);

    assert_inv_unord_R8: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> (flags_o == 4'b0011));

    assert_inv_excl_R9: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> !undef_o);
endmodule

bind fcc_flag_unit fcc_flag_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .flags_o   (flags_o),
    .invalid_o (invalid_o),
    .undef_o   (undef_o)
);

// File: tb/fcc_flag_unit_tb.sv
module fcc_flag_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        half_en_i = 1'b0;
    logic [3:0]  flags_o;
    logic        invalid_o;
    logic        undef_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcc_flag_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .opa_i(opa_i), .opb_i(opb_i), .half_en_i(half_en_i),
        .flags_o(flags_o), .invalid_o(invalid_o), .undef_o(undef_o)
    );

    localparam logic [1:0] T_S = 2'b00, T_D = 2'b01, T_X = 2'b10, T_H = 2'b11;
    localparam logic [3:0] AL = 4'b1110;

    localparam logic [63:0] S_ONE = 64'h3F80_0000, S_TWO = 64'h4000_0000;
    localparam logic [63:0] S_MONE = 64'hBF80_0000, S_PZ = 64'h0, S_NZ = 64'h8000_0000;
    localparam logic [63:0] S_PINF = 64'h7F80_0000, S_NINF = 64'hFF80_0000;
    localparam logic [63:0] S_QNAN = 64'h7FC0_0000, S_SNAN = 64'h7F80_0001;

    function automatic logic [31:0] mk(input logic [1:0] ft, input logic [3:0] cnd,
                                       input logic op, input logic [3:0] imm);
        return {3'b000, 5'b11110, ft, 1'b1, 5'd2, cnd, 2'b01, 5'd1, op, imm};
    endfunction

    task automatic chk(input string req, input string what, input logic [3:0] act,
                       input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic hen);
        @(negedge clk);
        instr_i = ins; opa_i = a; opb_i = b; half_en_i = hen; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "flags", flags_o, 4'b0000);
        chk("R1", "invalid", {3'b0, invalid_o}, 4'b0);
        chk("R1", "undef", {3'b0, undef_o}, 4'b0);
    endtask

    task automatic t_ordered;
        run(mk(T_S, AL, 1'b0, 4'h0), S_ONE, S_TWO, 1'b0);  chk("R6", "1<2", flags_o, 4'b1000);
        run(mk(T_S, AL, 1'b0, 4'h0), S_TWO, S_ONE, 1'b0);  chk("R6", "2>1", flags_o, 4'b0010);
        run(mk(T_S, AL, 1'b0, 4'h0), S_ONE, S_ONE, 1'b0);  chk("R6", "1==1", flags_o, 4'b0110);
        run(mk(T_S, AL, 1'b0, 4'h0), S_MONE, S_ONE, 1'b0); chk("R6", "-1<1", flags_o, 4'b1000);
        run(mk(T_D, AL, 1'b0, 4'h0), 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0);
        chk("R3", "double 1<2", flags_o, 4'b1000);
    endtask

    task automatic t_special;
        run(mk(T_S, AL, 1'b0, 4'h0), S_PZ, S_NZ, 1'b0);     chk("R7", "+0==-0", flags_o, 4'b0110);
        run(mk(T_S, AL, 1'b0, 4'h0), S_NINF, S_PINF, 1'b0); chk("R7", "-inf<inf", flags_o, 4'b1000);
        run(mk(T_S, AL, 1'b0, 4'h0), S_PINF, S_PINF, 1'b0); chk("R7", "inf==inf", flags_o, 4'b0110);
    endtask

    task automatic t_narrow;
        run(mk(T_S, AL, 1'b0, 4'h0), 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 1'b0);
        chk("R13", "single upper junk", flags_o, 4'b1000);
        run(mk(T_H, AL, 1'b0, 4'h0), 64'hFFFF_FFFF_FFFF_4000, 64'h0F0F_0F0F_0F0F_3C00, 1'b1);
        chk("R13", "half upper junk 2>1", flags_o, 4'b0010);
        chk("R3", "half accepted", {3'b0, undef_o}, 4'b0);
    endtask

    task automatic t_nan;
        run(mk(T_S, AL, 1'b0, 4'h0), S_QNAN, S_ONE, 1'b0);
        chk("R8", "qnan flags", flags_o, 4'b0011);
        chk("R9", "qnan quiet", {3'b0, invalid_o}, 4'b0);
        run(mk(T_S, AL, 1'b0, 4'h0), S_ONE, S_SNAN, 1'b0);
        chk("R8", "snan flags", flags_o, 4'b0011);
        chk("R9", "snan invalid", {3'b0, invalid_o}, 4'b1);
        run(mk(T_S, AL, 1'b1, 4'h0), S_QNAN, S_ONE, 1'b0);
        chk("R10", "qnan signal-all", {3'b0, invalid_o}, 4'b1);
        run(mk(T_H, AL, 1'b0, 4'h0), 64'h7C01, 64'h3C00, 1'b1);
        chk("R9", "half snan", {3'b0, invalid_o}, 4'b1);
    endtask

    task automatic t_cond_sweep(input logic [63:0] a, input logic [63:0] b,
                                input logic [3:0] start, input logic [15:0] mask);
        for (int c = 0; c < 16; c++) begin
            run(mk(T_S, AL, 1'b0, 4'h0), a, b, 1'b0);
            chk("R5", "start state", flags_o, start);
            run(mk(T_S, 4'(c), 1'b0, 4'b0001), S_ONE, S_TWO, 1'b0);
            chk(mask[c] ? "R5" : "R4", $sformatf("cond %0d from %b", c, start),
                flags_o, mask[c] ? 4'b1000 : 4'b0001);
        end
    endtask

    task automatic t_fail_quiet;
        run(mk(T_S, AL, 1'b0, 4'h0), S_TWO, S_ONE, 1'b0);
        run(mk(T_S, 4'b0000, 1'b0, 4'b0100), S_SNAN, S_SNAN, 1'b0);
        chk("R11", "failed cond no invalid", {3'b0, invalid_o}, 4'b0);
        chk("R4", "imm loaded", flags_o, 4'b0100);
    endtask

    task automatic t_undef;
        run(mk(T_S, AL, 1'b0, 4'h0), S_ONE, S_ONE, 1'b0);
        run(mk(T_X, AL, 1'b0, 4'h9), S_ONE, S_TWO, 1'b0);
        chk("R3", "type 10 undef", {3'b0, undef_o}, 4'b1);
        chk("R3", "type 10 flags kept", flags_o, 4'b0110);
        run(mk(T_H, AL, 1'b0, 4'h9), 64'h3C00, 64'h4000, 1'b0);
        chk("R3", "half disabled undef", {3'b0, undef_o}, 4'b1);
        chk("R3", "half disabled flags kept", flags_o, 4'b0110);
        run(mk(T_S, AL, 1'b0, 4'h9) & ~32'h0020_0000, S_ONE, S_TWO, 1'b0);
        chk("R2", "bit21 clear undef", {3'b0, undef_o}, 4'b1);
        chk("R2", "bit21 flags kept", flags_o, 4'b0110);
        run(mk(T_S, AL, 1'b0, 4'h9) ^ 32'h0000_0C00, S_ONE, S_TWO, 1'b0);
        chk("R2", "bits11..10 undef", {3'b0, undef_o}, 4'b1);
    endtask

    task automatic t_hold;
        run(mk(T_S, AL, 1'b1, 4'h0), S_SNAN, S_ONE, 1'b0);
        @(negedge clk);
        instr_i = mk(T_X, 4'b0001, 1'b0, 4'hF); opa_i = S_ONE; opb_i = S_TWO;
        @(negedge clk);
        chk("R12", "flags held", flags_o, 4'b0011);
        chk("R12", "invalid pulse ended", {3'b0, invalid_o}, 4'b0);
        chk("R12", "undef idle", {3'b0, undef_o}, 4'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ordered();
        t_special();
        t_narrow();
        t_nan();
        t_cond_sweep(S_TWO, S_ONE, 4'b0010, 16'hD5A6);
        t_cond_sweep(S_QNAN, S_ONE, 4'b0011, 16'hE966);
        t_cond_sweep(S_ONE, S_TWO, 4'b1000, 16'hEA9A);
        t_cond_sweep(S_ONE, S_ONE, 4'b0110, 16'hE6A5);
        t_fail_quiet();
        t_undef();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule